// File: doc/BRIEF.md
# Transmit Holding-Register-Empty Interrupt Logic

This block keeps the occupancy of a 16-entry UART transmit queue. From that count it derives the "holding register empty" status flag and the transmit interrupt request. CPU writes to the holding register push a character into the queue. The serializer takes characters out with a one-cycle pop strobe. When the queue drains, the block raises the empty flag and latches a pending transmit interrupt. The interrupt is reported with identification code 2h while both the FIFO enable and the transmit-interrupt enable inputs are high. This code ranks below every receive source, which are handled elsewhere.

The timing of the empty flag depends on how the queue was used. If two or more characters sat in the queue together since the flag last rose, the flag returns as soon as the queue is empty. If only one character was queued at a time, the flag is held back for one character time minus the final stop bit. This delay is measured as `CHAR_BITS-1` pulses of a bit-time tick. A change of the FIFO enable input re-raises the interrupt at once when the transmit interrupt is enabled and the queue is empty. Software clears the interrupt either by writing a character or by reading the identification register while code 2h is shown.

Top module: `txe_intr_top`

## Requirements
- R1: While reset is active and directly after it, `fill_level` is 0, `thr_empty` is 1, `tx_irq` is 0 and `irq_id` is 4'h1 (no source pending).
- R2: A `thr_wr` pulse raises `fill_level` by one at the next clock edge, and a `ser_pop` pulse lowers it by one. A write at level 16 without a simultaneous pop is dropped, a pop at level 0 is dropped, and a write together with a pop leaves the level unchanged unless the level is 0. The level never exceeds 16.
- R3: `thr_empty` falls on the same clock edge at which a write is accepted, and it is only ever 1 while `fill_level` is 0.
- R4: If `fill_level` reached 2 or more at any time since `thr_empty` last rose, `thr_empty` rises one clock edge after `fill_level` becomes 0.
- R5: Otherwise, after the level becomes 0, one setup edge passes. `thr_empty` then rises on the edge that takes the `CHAR_BITS-1`-th `bit_tick` pulse after that setup edge. An accepted write during this wait cancels it.
- R6: A pending flag is set one edge after `thr_empty` rises. `tx_irq` is 1 exactly while the pending flag, `fifo_en` and `tx_ie` are all 1. `irq_id` is 4'h2 while `tx_irq` is 1 and 4'h1 otherwise.
- R7: A `thr_wr` pulse, or an `iir_rd` pulse while `tx_irq` is 1, clears the pending flag at the next edge. The flag then stays clear until `thr_empty` rises again. An `iir_rd` while `tx_irq` is 0 has no effect.
- R8: When `fifo_en` differs from its value on the previous clock, `tx_ie` is 1 and `thr_empty` is 1, the pending flag is set at the next edge, with no character-time delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| thr_wr | input | 1 | CPU write strobe to the holding register (push) |
| iir_rd | input | 1 | CPU read strobe of the interrupt identification register |
| fifo_en | input | 1 | FIFO enable control bit |
| tx_ie | input | 1 | Transmit interrupt enable bit |
| ser_pop | input | 1 | Serializer pop strobe |
| bit_tick | input | 1 | One pulse per serial bit time |
| fill_level | output | 5 | Current queue occupancy, 0 to 16 |
| thr_empty | output | 1 | Holding register empty status flag |
| tx_irq | output | 1 | Transmit interrupt request |
| irq_id | output | 4 | Identification code: 4'h2 when `tx_irq` is set, else 4'h1 |

## Verification
The level and the fall of `thr_empty` are due on the edge that takes the strobe. The fast rise of `thr_empty` comes one edge after the level reaches zero. The slow rise comes one setup edge after that, plus the chosen number of tick edges. The pending flag follows one edge after a rise or a `fifo_en` change, while the enable gating on `tx_irq` acts within the same cycle. The bench applies every stimulus just after a falling edge and compares all outputs 1 ns after the following rising edge. As a result, each expected value in its table is the state after exactly one more register stage, and the delay cases are spelled out edge by edge.

// File: rtl/txe_pkg.sv
package txe_pkg;
    localparam int IID_W = 4;
    localparam logic [IID_W-1:0] IID_NONE = 4'h1;
    localparam logic [IID_W-1:0] IID_THRE = 4'h2;

    typedef enum logic {
        DS_IDLE = 1'b0,
        DS_WAIT = 1'b1
    } dly_state_e;
endpackage

// File: rtl/txe_fill_count.sv
module txe_fill_count #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             push_acc_o,
    output logic [LVL_W-1:0] level_o
);
    typedef struct packed {
        logic [LVL_W-1:0] level;
    } fill_t;

    fill_t q, d;
    logic  full, empty, push_ok, pop_ok;

    always_comb begin
        d       = q;
        full    = (q.level == LVL_W'(DEPTH));
        empty   = (q.level == '0);
        pop_ok  = pop_i && !empty;
        push_ok = push_i && (!full || pop_i);
        if (push_ok && !pop_ok)
            d.level = q.level + LVL_W'(1);
        else if (pop_ok && !push_ok)
            d.level = q.level - LVL_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign push_acc_o = push_ok;
    assign level_o    = q.level;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.level <= LVL_W'(DEPTH));
endmodule

// File: rtl/txe_empty_track.sv
module txe_empty_track
    import txe_pkg::*;
#(
    parameter int LVL_W     = 5,
    parameter int CHAR_BITS = 10,
    localparam int DCNT_W   = $clog2(CHAR_BITS),
    localparam int DLY      = CHAR_BITS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_acc_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             bit_tick_i,
    output logic             thre_o
);
    typedef struct packed {
        logic              thre;
        dly_state_e        st;
        logic [DCNT_W-1:0] dcnt;
        logic              multi;
    } trk_t;

    localparam trk_t TRK_RST = '{thre: 1'b1, st: DS_IDLE, dcnt: '0, multi: 1'b0};

    trk_t q, d;

    always_comb begin
        d = q;
        if (push_acc_i) begin
            d.thre = 1'b0;
            d.st   = DS_IDLE;
        end else if (level_i != '0) begin
            d.st = DS_IDLE;
        end else if (!q.thre) begin
            if (q.st == DS_WAIT) begin
                if (bit_tick_i) begin
                    if (q.dcnt == DCNT_W'(1)) begin
                        d.thre = 1'b1;
                        d.st   = DS_IDLE;
                    end else begin
                        d.dcnt = q.dcnt - DCNT_W'(1);
                    end
                end
            end else if (q.multi) begin
                d.thre = 1'b1;
            end else begin
                d.st   = DS_WAIT;
                d.dcnt = DCNT_W'(DLY);
            end
        end
        if (level_i >= LVL_W'(2))
            d.multi = 1'b1;
        if (d.thre && !q.thre)
            d.multi = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= TRK_RST;
        else        q <= d;
    end

    assign thre_o = q.thre;

    assert_empty_only_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.thre |-> (level_i == '0));

    assert_write_drops_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push_acc_i |=> !thre_o);
endmodule

// File: rtl/txe_irq_ctl.sv
module txe_irq_ctl
    import txe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thre_i,
    input  logic             thr_wr_i,
    input  logic             iir_rd_i,
    input  logic             fifo_en_i,
    input  logic             tx_ie_i,
    output logic             tx_irq_o,
    output logic [IID_W-1:0] irq_id_o
);
    typedef struct packed {
        logic pend;
        logic thre_seen;
        logic fen_seen;
    } irq_t;

    localparam irq_t IRQ_RST = '{pend: 1'b0, thre_seen: 1'b1, fen_seen: 1'b0};

    irq_t q, d;
    logic rise, fen_chg, clr;

    assign tx_irq_o = q.pend && fifo_en_i && tx_ie_i;
    assign irq_id_o = tx_irq_o ? IID_THRE : IID_NONE;

    always_comb begin
        d           = q;
        d.thre_seen = thre_i;
        d.fen_seen  = fifo_en_i;
        rise        = thre_i && !q.thre_seen;
        fen_chg     = fifo_en_i ^ q.fen_seen;
        clr         = thr_wr_i || (iir_rd_i && tx_irq_o);
        if (clr)
            d.pend = 1'b0;
        else if (rise || (fen_chg && tx_ie_i && thre_i))
            d.pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= IRQ_RST;
        else        q <= d;
    end

    assert_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr_i |=> !tx_irq_o);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd_i && tx_irq_o) |=> !q.pend);

    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thre_i) && !thr_wr_i && !iir_rd_i) |=> q.pend);
endmodule

// File: rtl/txe_intr_top.sv
module txe_intr_top
    import txe_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CHAR_BITS = 10,
    localparam int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             fifo_en,
    input  logic             tx_ie,
    input  logic             ser_pop,
    input  logic             bit_tick,
    output logic [LVL_W-1:0] fill_level,
    output logic             thr_empty,
    output logic             tx_irq,
    output logic [IID_W-1:0] irq_id
);
    logic push_acc;

    txe_fill_count #(.DEPTH(DEPTH)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (thr_wr),
        .pop_i      (ser_pop),
        .push_acc_o (push_acc),
        .level_o    (fill_level)
    );

    txe_empty_track #(.LVL_W(LVL_W), .CHAR_BITS(CHAR_BITS)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_acc_i (push_acc),
        .level_i    (fill_level),
        .bit_tick_i (bit_tick),
        .thre_o     (thr_empty)
    );

    txe_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .thre_i    (thr_empty),
        .thr_wr_i  (thr_wr),
        .iir_rd_i  (iir_rd),
        .fifo_en_i (fifo_en),
        .tx_ie_i   (tx_ie),
        .tx_irq_o  (tx_irq),
        .irq_id_o  (irq_id)
    );
endmodule

// File: tb/tb_txe_intr_top.sv
`timescale 1ns/1ps
module tb_txe_intr_top;
    localparam int DEPTH = 16;
    localparam int CB    = 4;   // delay = 3 ticks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       thr_wr = 0, iir_rd = 0, fifo_en = 0, tx_ie = 0, ser_pop = 0, bit_tick = 0;
    logic [4:0] fill_level;
    logic       thr_empty, tx_irq;
    logic [3:0] irq_id;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    txe_intr_top #(.DEPTH(DEPTH), .CHAR_BITS(CB)) dut (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .iir_rd(iir_rd),
        .fifo_en(fifo_en), .tx_ie(tx_ie), .ser_pop(ser_pop), .bit_tick(bit_tick),
        .fill_level(fill_level), .thr_empty(thr_empty), .tx_irq(tx_irq), .irq_id(irq_id)
    );

    always #2.5 clk = ~clk;

    // {wr, rd, fen, ie, pop, tick} , level , thre , irq
    localparam logic [12:0] VEC [34] = '{
        {6'b001100, 5'd0, 1'b1, 1'b1},  // 0  R8 enable change
        {6'b011100, 5'd0, 1'b1, 1'b0},  // 1  R7 read clears
        {6'b101100, 5'd1, 1'b0, 1'b0},  // 2  R2 R3 single write
        {6'b001100, 5'd1, 1'b0, 1'b0},  // 3
        {6'b001110, 5'd0, 1'b0, 1'b0},  // 4  pop to empty
        {6'b001100, 5'd0, 1'b0, 1'b0},  // 5  R5 setup edge
        {6'b001101, 5'd0, 1'b0, 1'b0},  // 6  tick 1
        {6'b001100, 5'd0, 1'b0, 1'b0},  // 7
        {6'b001101, 5'd0, 1'b0, 1'b0},  // 8  tick 2
        {6'b001101, 5'd0, 1'b1, 1'b0},  // 9  tick 3: R5 rise
        {6'b001100, 5'd0, 1'b1, 1'b1},  // 10 R6 pending
        {6'b101100, 5'd1, 1'b0, 1'b0},  // 11 R7 write clears
        {6'b101100, 5'd2, 1'b0, 1'b0},  // 12 two queued
        {6'b001110, 5'd1, 1'b0, 1'b0},  // 13
        {6'b001110, 5'd0, 1'b0, 1'b0},  // 14
        {6'b001100, 5'd0, 1'b1, 1'b0},  // 15 R4 immediate
        {6'b001100, 5'd0, 1'b1, 1'b1},  // 16
        {6'b001000, 5'd0, 1'b1, 1'b0},  // 17 R6 ie gate
        {6'b001100, 5'd0, 1'b1, 1'b1},  // 18
        {6'b000100, 5'd0, 1'b1, 1'b0},  // 19 R6 fen gate
        {6'b001100, 5'd0, 1'b1, 1'b1},  // 20
        {6'b011100, 5'd0, 1'b1, 1'b0},  // 21 R7
        {6'b101100, 5'd1, 1'b0, 1'b0},  // 22
        {6'b001110, 5'd0, 1'b0, 1'b0},  // 23
        {6'b001100, 5'd0, 1'b0, 1'b0},  // 24 setup
        {6'b001101, 5'd0, 1'b0, 1'b0},  // 25 tick 1
        {6'b101100, 5'd1, 1'b0, 1'b0},  // 26 R5 cancel
        {6'b001101, 5'd1, 1'b0, 1'b0},  // 27
        {6'b001110, 5'd0, 1'b0, 1'b0},  // 28
        {6'b001100, 5'd0, 1'b0, 1'b0},  // 29 setup
        {6'b001101, 5'd0, 1'b0, 1'b0},  // 30
        {6'b001101, 5'd0, 1'b0, 1'b0},  // 31
        {6'b001101, 5'd0, 1'b1, 1'b0},  // 32 full delay again
        {6'b001100, 5'd0, 1'b1, 1'b1}   // 33
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic [5:0] s);
        @(negedge clk);
        {thr_wr, iir_rd, fifo_en, tx_ie, ser_pop, bit_tick} = s;
        @(posedge clk);
        #1;
    endtask

    task automatic chk_all(input string tag, input int lvl, input int th, input int irq);
        chk({tag, " level R2"}, fill_level, lvl);
        chk({tag, " thre R3/R4/R5"}, thr_empty, th);
        chk({tag, " irq R6"}, tx_irq, irq);
        chk({tag, " id R6"}, irq_id, irq ? 2 : 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_all("R1 reset", 0, 1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk_all("R1 after reset", 0, 1, 0);

        for (int i = 0; i < 34; i++) begin
            step(VEC[i][12:7]);
            chk_all($sformatf("vec %0d", i), VEC[i][6:2], VEC[i][1], VEC[i][0]);
        end

        // R7: read while the request is masked is ignored
        step(6'b011000);
        chk("R7 masked read", tx_irq, 0);
        step(6'b001100);
        chk("R7 pending kept", tx_irq, 1);

        // R2: fill to the limit and one extra write
        for (int k = 1; k <= DEPTH + 1; k++) begin
            step(6'b101100);
            chk("R2 fill", fill_level, (k > DEPTH) ? DEPTH : k);
        end
        chk("R7 write cleared", tx_irq, 0);
        step(6'b101110);
        chk("R2 push+pop at full", fill_level, DEPTH);
        for (int k = DEPTH - 1; k >= 0; k--) begin
            step(6'b001110);
            chk("R2 drain", fill_level, k);
        end
        chk("R3 still low at zero", thr_empty, 0);
        step(6'b001100);
        chk("R4 immediate rise", thr_empty, 1);
        step(6'b001100);
        chk("R6 pending after drain", tx_irq, 1);
        step(6'b001110);
        chk("R2 pop on empty", fill_level, 0);
        chk("R2 pop on empty thre", thr_empty, 1);
        step(6'b101110);
        chk("R2 push+pop at empty", fill_level, 1);
        chk("R3 push+pop at empty", thr_empty, 0);
        step(6'b001100);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule